// File: doc/BRIEF.md
# Sector Protection and Lockdown Unit

This unit keeps the write-protection state of a flash array built from 32 sectors of 64 KB. It accepts commands that the serial front end has already decoded (an opcode, a 24-bit address and an optional data byte, marked by a one-cycle valid strobe). Each sector has two state bits. The soft protect bit can be set and cleared. The lockdown bit can only ever be set. A freeze flag stops any further lockdown. A write-protect pin, active low, pins the soft protect bits so that they cannot be cleared. A write-enable latch must be set before any command that changes state.

The unit answers queries in two ways. A protection query or a lockdown query returns a byte one cycle after the command strobe. A separate check address is compared against the state at all times, and the result is an allow flag that the program and erase sequencer uses to refuse writes to guarded sectors. The sector index is taken from address bits 20 to 16. Bits 23 to 21 are ignored.

Top module: `sector_guard`

## Requirements
- R1: After reset every sector is protected, the write-enable latch is clear and `rd_valid` is low.
- R2: Opcode 0x06 sets the write-enable latch and 0x04 clears it. The latch also clears after any of the opcodes 0x36, 0x39, 0x33, 0x34 or 0x01, whether or not that command had an effect.
- R3: With the latch set, 0x36 protects the sector selected by address bits 20..16 and 0x39 unprotects it. Address bits 23..21 do not take part in the selection. Without the latch, both commands leave the state unchanged.
- R4: Opcode 0x3C makes `rd_valid` high in the next cycle, with `rd_data` equal to 0xFF if the addressed sector is protected and 0x00 if it is not. Other opcodes leave `rd_valid` low.
- R5: Opcode 0x33 locks the addressed sector down only when the latch is set, the data byte is 0xD0 and lockdown is not frozen. Any other data byte is ignored. Opcode 0x35 returns 0xFF for a locked sector and 0x00 otherwise, with the same timing as R4.
- R6: No command and no reset ever clears a lockdown bit. An unprotect of a locked sector leaves it reading as protected.
- R7: Opcode 0x34 with the latch set and data byte 0x55 freezes lockdown, and every later 0x33 then has no effect. A freeze command with any other data byte is ignored.
- R8: With the latch set, opcode 0x01 with data bits 5..2 equal to 1111 protects every sector. With those bits equal to 0000 it unprotects every sector that is not locked down. Any other value of those bits leaves protection unchanged.
- R9: While `wp_n` is low, neither 0x39 nor 0x01 clears any protect bit, but 0x36 and global protect still set protect bits.
- R10: `chk_allow` is high exactly when the write-enable latch is set and the sector selected by `chk_addr` is neither protected nor locked down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle strobe for a decoded command |
| cmd_op | input | 8 | Command opcode |
| cmd_addr | input | 24 | Command address |
| cmd_data | input | 8 | Command data byte |
| wp_n | input | 1 | Write-protect pin, active low |
| chk_addr | input | 24 | Address checked for program or erase permission |
| chk_allow | output | 1 | Program or erase at `chk_addr` is permitted |
| wel | output | 1 | Write-enable latch state |
| rd_valid | output | 1 | Query response is valid |
| rd_data | output | 8 | Query response byte |

## Verification
A table of command sequences drives the protect, unprotect, lockdown and global paths. It covers the latch set and the latch clear, key bytes that are correct and key bytes that are wrong, and addresses whose ignored upper bits alias to a sector that has already been touched. Each sequence ends with a query, so the bench can tell whether a command was gated by the latch, gated by its key, or selected the wrong sector. Directed tests then cover the permission flag for a writable sector, a locked sector and a protected sector. They also hold the write-protect pin low while unprotect and global unprotect are issued, freeze lockdown and try to lock again, and apply reset to show that lockdown survives it while soft protection returns.

// File: rtl/sector_guard.sv
module sector_guard #(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 8,
  parameter int NSEC       = 32,
  parameter int SEC_LSB    = 16,
  parameter int GLB_LSB    = 2,
  parameter int GLB_W      = 4,
  parameter logic [7:0] LOCK_KEY   = 8'hD0,
  parameter logic [7:0] FREEZE_KEY = 8'h55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              wp_n,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              chk_allow,
  output logic              wel,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  localparam int SEC_W = $clog2(NSEC);
  localparam logic [7:0] OP_PROT = 8'h36, OP_UNPROT = 8'h39, OP_RDPROT = 8'h3C,
                         OP_LOCK = 8'h33, OP_FREEZE = 8'h34, OP_RDLOCK = 8'h35,
                         OP_STAT = 8'h01, OP_WREN  = 8'h06, OP_WRDI  = 8'h04;

  logic [NSEC-1:0] prot_q;
  logic [NSEC-1:0] lock_q = '0;
  logic            frz_q  = 1'b0;
  logic            wel_q;

  wire [SEC_W-1:0] cmd_sec = cmd_addr[SEC_LSB +: SEC_W];
  wire [SEC_W-1:0] chk_sec = chk_addr[SEC_LSB +: SEC_W];
  wire [GLB_W-1:0] glb     = cmd_data[GLB_LSB +: GLB_W];
  wire             go      = cmd_valid & wel_q;
  wire             changer = (cmd_op == OP_PROT) || (cmd_op == OP_UNPROT) || (cmd_op == OP_LOCK) ||
                             (cmd_op == OP_FREEZE) || (cmd_op == OP_STAT);
  wire             is_rd   = (cmd_op == OP_RDPROT) || (cmd_op == OP_RDLOCK);

  always_ff @(posedge clk) begin
    if (!rst_n) prot_q <= '1;
    else if (go) begin
      case (cmd_op)
        OP_PROT:   prot_q[cmd_sec] <= 1'b1;
        OP_UNPROT: if (wp_n && !lock_q[cmd_sec]) prot_q[cmd_sec] <= 1'b0;
        OP_STAT: begin
          if (glb == '1) prot_q <= '1;
          else if (glb == '0 && wp_n) prot_q <= prot_q & lock_q;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (go && cmd_op == OP_LOCK && cmd_data == LOCK_KEY && !frz_q) lock_q[cmd_sec] <= 1'b1;
    if (go && cmd_op == OP_FREEZE && cmd_data == FREEZE_KEY) frz_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) wel_q <= 1'b0;
    else if (cmd_valid) begin
      if (cmd_op == OP_WREN) wel_q <= 1'b1;
      else if (cmd_op == OP_WRDI || changer) wel_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= cmd_valid & is_rd;
      if (cmd_valid && is_rd)
        rd_data <= ((cmd_op == OP_RDPROT) ? prot_q[cmd_sec] : lock_q[cmd_sec]) ? '1 : '0;
    end
  end

  assign wel       = wel_q;
  assign chk_allow = wel_q & ~prot_q[chk_sec] & ~lock_q[chk_sec];

  // R6
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q & $past(lock_q)) == $past(lock_q));
  // R7
  frozen_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frz_q |=> $stable(lock_q));
  // R9
  wp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_n |=> (prot_q & $past(prot_q)) == $past(prot_q));
  // R2
  wel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && changer) |=> !wel);
  // R4
  rd_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !is_rd) |=> !rd_valid);
  // R5
  lock_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && cmd_op == OP_LOCK && cmd_data == LOCK_KEY && !frz_q) |=> lock_q[$past(cmd_sec)]);
endmodule

// File: tb/sector_guard_bench.sv
module sector_guard_bench;
  logic        clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0, wp_n = 1'b1;
  logic [7:0]  cmd_op = '0, cmd_data = '0;
  logic [23:0] cmd_addr = '0, chk_addr = '0;
  logic        chk_allow, wel, rd_valid;
  logic [7:0]  rd_data;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  sector_guard u_sector_guard (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .wp_n(wp_n), .chk_addr(chk_addr),
    .chk_allow(chk_allow), .wel(wel), .rd_valid(rd_valid), .rd_data(rd_data));

  // {op, addr, data, read_expected, read_value}
  localparam int NV = 25;
  localparam logic [48:0] VEC [NV] = '{
    {8'h3C, 24'h050000, 8'h00, 9'h1FF},  // R1 protected after reset
    {8'h39, 24'h050000, 8'h00, 9'h000},  // R3 no latch
    {8'h3C, 24'h050000, 8'h00, 9'h1FF},
    {8'h06, 24'h000000, 8'h00, 9'h000},
    {8'h39, 24'h050000, 8'h00, 9'h000},
    {8'h3C, 24'h050000, 8'h00, 9'h100},  // R3 unprotected
    {8'h3C, 24'h060000, 8'h00, 9'h1FF},  // R3 neighbour intact
    {8'h39, 24'h060000, 8'h00, 9'h000},  // R2 latch cleared by prior
    {8'h3C, 24'h060000, 8'h00, 9'h1FF},
    {8'h06, 24'h000000, 8'h00, 9'h000},
    {8'h33, 24'h070000, 8'h12, 9'h000},  // R5 wrong key
    {8'h35, 24'h070000, 8'h00, 9'h100},
    {8'h06, 24'h000000, 8'h00, 9'h000},
    {8'h33, 24'h070000, 8'hD0, 9'h000},
    {8'h35, 24'h070000, 8'h00, 9'h1FF},  // R5 locked
    {8'h06, 24'h000000, 8'h00, 9'h000},
    {8'h39, 24'h070000, 8'h00, 9'h000},
    {8'h3C, 24'h070000, 8'h00, 9'h1FF},  // R6 locked stays protected
    {8'h3C, 24'hE50000, 8'h00, 9'h100},  // R3 upper bits ignored
    {8'h06, 24'h000000, 8'h00, 9'h000},
    {8'h01, 24'h000000, 8'h00, 9'h000},  // R8 global unprotect
    {8'h3C, 24'h0A0000, 8'h00, 9'h100},
    {8'h3C, 24'h070000, 8'h00, 9'h1FF},  // R8 locked kept
    {8'h06, 24'h000000, 8'h00, 9'h000},
    {8'h01, 24'h000000, 8'h3C, 9'h000}   // R8 global protect
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [7:0] op, input logic [23:0] a, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic query(input string req, input logic [7:0] op, input logic [23:0] a,
                       input logic [7:0] exp);
    cmd(op, a, 8'h00);
    chk(req, {7'd0, rd_valid}, 8'd1);
    chk(req, rd_data, exp);
  endtask

  task automatic allow(input string req, input logic [23:0] a, input logic exp);
    chk_addr = a;
    #1;
    chk(req, {7'd0, chk_allow}, {7'd0, exp});
  endtask

  initial begin
    #150000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 wel", {7'd0, wel}, 8'd0);
    chk("R1 rd_valid", {7'd0, rd_valid}, 8'd0);

    for (int i = 0; i < NV; i++) begin
      cmd(VEC[i][48:41], VEC[i][40:17], VEC[i][16:9]);
      chk($sformatf("R4 vec%0d rd_valid", i), {7'd0, rd_valid}, {7'd0, VEC[i][8]});
      if (VEC[i][8]) chk($sformatf("R4 vec%0d rd_data", i), rd_data, VEC[i][7:0]);
    end
    query("R8 protect all", 8'h3C, 24'h050000, 8'hFF);
    cmd(8'h06, 0, 0);
    cmd(8'h01, 0, 8'h24);
    query("R8 other field", 8'h3C, 24'h050000, 8'hFF);

    cmd(8'h06, 0, 0);
    chk("R2 set", {7'd0, wel}, 8'd1);
    cmd(8'h39, 24'h030000, 0);
    chk("R2 clear", {7'd0, wel}, 8'd0);
    cmd(8'h06, 0, 0);
    allow("R10 open", 24'h031234, 1'b1);
    allow("R10 locked", 24'h07FFFF, 1'b0);
    allow("R10 protected", 24'h040000, 1'b0);
    cmd(8'h04, 0, 0);
    allow("R10 no latch", 24'h031234, 1'b0);
    chk("R2 wrdi", {7'd0, wel}, 8'd0);

    wp_n = 1'b0;
    cmd(8'h06, 0, 0); cmd(8'h39, 24'h040000, 0);
    query("R9 unprotect blocked", 8'h3C, 24'h040000, 8'hFF);
    cmd(8'h06, 0, 0); cmd(8'h01, 0, 8'h00);
    query("R9 global blocked", 8'h3C, 24'h040000, 8'hFF);
    cmd(8'h06, 0, 0); cmd(8'h36, 24'h030000, 0);
    query("R9 protect allowed", 8'h3C, 24'h030000, 8'hFF);
    wp_n = 1'b1;

    cmd(8'h06, 0, 0); cmd(8'h34, 0, 8'h12);
    cmd(8'h06, 0, 0); cmd(8'h33, 24'h090000, 8'hD0);
    query("R7 bad key ignored", 8'h35, 24'h090000, 8'hFF);
    cmd(8'h06, 0, 0); cmd(8'h34, 0, 8'h55);
    cmd(8'h06, 0, 0); cmd(8'h33, 24'h0A0000, 8'hD0);
    query("R7 frozen", 8'h35, 24'h0A0000, 8'h00);

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R1 wel after reset", {7'd0, wel}, 8'd0);
    query("R6 lock survives reset", 8'h35, 24'h070000, 8'hFF);
    cmd(8'h06, 0, 0); cmd(8'h01, 0, 8'h00);
    query("R1 protect restored then global", 8'h3C, 24'h0B0000, 8'h00);
    query("R6 locked after global", 8'h3C, 24'h090000, 8'hFF);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule